// File: doc/BRIEF.md
# AC-link Reset and Wake Controller

This block sequences the reset and low-power states of a codec attached over an AC-link. A host writes a 16-bit control word through a plain write port and reads it back. The word requests a cold reset, which drives the codec's active-low reset line low, or a warm reset, which drives the frame sync line high. Each pulse lasts at least 1.2 µs, counted in system clock cycles, and the request bit clears itself when the pulse ends. A monitor watches the codec's bit clock through a two-flop synchroniser. It declares the clock stopped after a programmable number of system cycles with no edge.

While shut-off mode is enabled and the bit clock is stopped, the block drives every link output low and turns off the line-in input buffer. A rising edge on the serial data input from the codec is then treated as a wake-up. The wake status flag is always latched. The host interrupt and the power-management request are each gated by their own enable bit. A separate status port reads the wake and power-management flags and clears them by writing 1.

The block also provides two further functions. A loopback bit feeds the core's serial data output back into the core's serial data input in place of the codec pin. An enable gates a one-cycle interrupt whenever the GPI status bit taken from the incoming frame changes. The shut-off and power-management enables are kept across a main reset and are cleared only by the auxiliary-power reset.

Top module: `aclink_pm_ctrl`

## Requirements
- R1: Writing 1 to control bit 1 while no cold pulse runs drives `codec_rst_n` low for exactly PULSE_CYC system cycles (300 at 250 MHz), starting the cycle after the write. Bit 1 reads 1 during the pulse and 0 after it.
- R2: Writing 1 to control bit 2 while the bit clock is stopped drives `sync_out` high for exactly PULSE_CYC cycles, starting the cycle after the write. Bit 2 reads 1 during the pulse and clears itself afterwards.
- R3: A write of 1 to control bit 2 while the bit clock is running is ignored. Bit 2 stays 0 and `sync_out` keeps following `sync_core`.
- R4: `bclk_stopped` rises once no bit-clock edge has been seen for STOP_IDLE system cycles. It falls within a few cycles after the bit clock toggles again.
- R5: When control bit 3 (shut-off) is 1 and the bit clock is stopped, `codec_rst_n`, `sdata_out_pin`, `line_in_en` and `sync_out` (outside a warm pulse) are all 0. Otherwise `sync_out`/`sdata_out_pin` follow the core and `line_in_en` is 1.
- R6: A rising edge on `sdata_in_pin` while bit 3 is 1 and the bit clock is stopped sets wake status (status bit 4). The same edge at any other time leaves it 0.
- R7: `wake_irq` equals wake status AND control bit 4. A wake event with control bit 5 set also sets PME status (status bit 5), which drives `pme_req`. Writing 1 to status bit 4 or bit 5 clears that flag.
- R8: `sdata_in_core` equals `sdata_out_core` when control bit 7 is 1, and equals `sdata_in_pin` when bit 7 is 0.
- R9: With control bit 0 set, each change of `gpi_sts` raises `gpi_irq` for exactly one cycle, at the edge after the change. With bit 0 clear, `gpi_irq` stays 0.
- R10: Control bits 3 and 5 and PME status survive a main reset and clear on the auxiliary reset. All other control bits clear on a main reset.
- R11: Control bits 15..8 and bit 6 read 0 and ignore writes. Bits 0, 4, 5, 7 and 3 read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Main reset, asynchronous assert, active low |
| aux_rst_n | input | 1 | Auxiliary-power reset, clears sticky state, active low |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 16 | Control register write data |
| ctrl_rdata | output | 16 | Control register read data |
| sts_wr | input | 1 | Status write strobe (write 1 to clear) |
| sts_wdata | input | 8 | Status write data |
| sts_rdata | output | 8 | Status read: bit 4 wake, bit 5 PME |
| bclk_in | input | 1 | Codec bit clock, asynchronous |
| bclk_stopped | output | 1 | Bit clock judged stopped |
| sync_core | input | 1 | Frame sync from the frame logic |
| sdata_out_core | input | 1 | Serial data out from the frame logic |
| sdata_in_pin | input | 1 | Serial data in from the codec pin |
| sdata_in_core | output | 1 | Serial data in to the frame logic |
| codec_rst_n | output | 1 | Codec reset line, active low |
| sync_out | output | 1 | Sync line to the codec |
| sdata_out_pin | output | 1 | Serial data out to the codec |
| line_in_en | output | 1 | Line-in input buffer enable |
| gpi_sts | input | 1 | GPI status bit from the incoming frame |
| gpi_irq | output | 1 | GPI change interrupt pulse |
| wake_irq | output | 1 | Wake-up host interrupt |
| pme_req | output | 1 | Power-management event request |

## Verification
A pulse counter that is off by one shows up as a reset or sync pulse one cycle short or long, and it is visible when that pulse ends. A wrong bit-clock idle count makes shut-off forcing, warm-reset acceptance and wake arming start too early or too late, which shows a few cycles around the idle threshold. Wake state that is latched at the wrong time appears on `sts_rdata`, `wake_irq` or `pme_req` within a handful of cycles of the data edge. A register that was wrongly cleared by the wrong reset shows on the next read of `ctrl_rdata`.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int CTL_W   = 16;
  localparam int STS_W   = 8;
  // control bit positions
  localparam int B_GPIE  = 0;
  localparam int B_COLD  = 1;
  localparam int B_WARM  = 2;
  localparam int B_SHUT  = 3;
  localparam int B_WIE   = 4;
  localparam int B_PMEEN = 5;
  localparam int B_LOOP  = 7;
  // status bit positions
  localparam int S_WAKE  = 4;
  localparam int S_PME   = 5;

  typedef struct packed {
    logic loop_en;
    logic pme_en;
    logic wake_ie;
    logic shut_en;
    logic gpi_ie;
  } ctl_fields_t;
endpackage

// File: rtl/aclink_rst_sync.sv
module aclink_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/aclink_bclk_mon.sv
module aclink_bclk_mon #(
  parameter int STOP_IDLE = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  output logic stopped
);
  localparam int CW = $clog2(STOP_IDLE + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STOP_IDLE);

  logic [2:0]    sync_q;
  logic [CW-1:0] idle_q, idle_d;
  logic          edge_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 3'b000;
    else        sync_q <= {sync_q[1:0], bclk_in};
  end

  assign edge_seen = sync_q[2] ^ sync_q[1];

  always_comb begin
    idle_d = idle_q;
    if (edge_seen)            idle_d = '0;
    else if (idle_q != LIMIT) idle_d = idle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= '0;
    else        idle_q <= idle_d;
  end

  assign stopped = (idle_q == LIMIT);

  // R4: an observed edge always clears the stopped indication
  a_r4_edge_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> !stopped);
endmodule

// File: rtl/aclink_pulse_gen.sv
module aclink_pulse_gen #(
  parameter int CYC = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int CW = (CYC > 2) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_d;

  always_comb begin
    cnt_d = cnt_q;
    act_d = active;
    if (!active && start) begin
      act_d = 1'b1;
      cnt_d = LOAD;
    end else if (active) begin
      if (cnt_q == '0) act_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else begin
      active <= act_d;
      cnt_q  <= cnt_d;
    end
  end

  // checker: independent width counter for the minimum-width rule
  logic [CW+1:0] width_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 width_q <= '0;
    else if (!active && start)  width_q <= 1;
    else if (active)            width_q <= width_q + 1'b1;
  end

  // R1 and R2: every pulse lasts exactly CYC cycles
  a_r1_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ($past(width_q) == (CW+2)'(CYC)));
endmodule

// File: rtl/aclink_ctrl_regs.sv
module aclink_ctrl_regs
  import aclink_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             aux_rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wdata,
  input  logic             bclk_stopped,
  input  logic             cold_busy,
  input  logic             warm_busy,
  output logic             cold_start,
  output logic             warm_start,
  output ctl_fields_t      fields,
  output logic [CTL_W-1:0] rdata
);
  logic gpie_q, wie_q, loop_q, gpie_d, wie_d, loop_d;
  logic shut_q, pme_q, shut_d, pme_d;
  logic unused_rsvd;

  assign unused_rsvd = ^{wdata[15:8], wdata[6]};

  always_comb begin
    gpie_d = gpie_q;
    wie_d  = wie_q;
    loop_d = loop_q;
    shut_d = shut_q;
    pme_d  = pme_q;
    if (wr_en) begin
      gpie_d = wdata[B_GPIE];
      wie_d  = wdata[B_WIE];
      loop_d = wdata[B_LOOP];
      shut_d = wdata[B_SHUT];
      pme_d  = wdata[B_PMEEN];
    end
  end

  // main-reset domain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpie_q <= 1'b0;
      wie_q  <= 1'b0;
      loop_q <= 1'b0;
    end else begin
      gpie_q <= gpie_d;
      wie_q  <= wie_d;
      loop_q <= loop_d;
    end
  end

  // auxiliary-reset domain (sticky)
  always_ff @(posedge clk or negedge aux_rst_n) begin
    if (!aux_rst_n) begin
      shut_q <= 1'b0;
      pme_q  <= 1'b0;
    end else begin
      shut_q <= shut_d;
      pme_q  <= pme_d;
    end
  end

  assign cold_start = wr_en && wdata[B_COLD];
  assign warm_start = wr_en && wdata[B_WARM] && bclk_stopped;

  assign fields = '{loop_en: loop_q, pme_en: pme_q, wake_ie: wie_q,
                    shut_en: shut_q, gpi_ie: gpie_q};

  always_comb begin
    rdata          = '0;
    rdata[B_GPIE]  = gpie_q;
    rdata[B_COLD]  = cold_busy;
    rdata[B_WARM]  = warm_busy;
    rdata[B_SHUT]  = shut_q;
    rdata[B_WIE]   = wie_q;
    rdata[B_PMEEN] = pme_q;
    rdata[B_LOOP]  = loop_q;
  end

  // R3: a warm request with the bit clock running never starts a pulse
  a_r3_warm_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[B_WARM] && !bclk_stopped && !warm_busy) |=> !warm_busy);
endmodule

// File: rtl/aclink_wake_det.sv
module aclink_wake_det
  import aclink_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             aux_rst_n,
  input  logic             sdin_pin,
  input  logic             link_off,
  input  logic             wake_ie,
  input  logic             pme_en,
  input  logic             sts_wr,
  input  logic [STS_W-1:0] sts_wdata,
  output logic [STS_W-1:0] sts_rdata,
  output logic             wake_irq,
  output logic             pme_req
);
  logic [2:0] sd_q;
  logic       rise, wake_q, wake_d, pme_q, pme_d;
  logic       unused_sts;

  assign unused_sts = ^{sts_wdata[7:6], sts_wdata[3:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sd_q <= 3'b000;
    else        sd_q <= {sd_q[1:0], sdin_pin};
  end

  assign rise = sd_q[1] && !sd_q[2];

  always_comb begin
    wake_d = wake_q;
    pme_d  = pme_q;
    if (sts_wr && sts_wdata[S_WAKE]) wake_d = 1'b0;
    if (sts_wr && sts_wdata[S_PME])  pme_d  = 1'b0;
    if (rise && link_off) begin
      wake_d = 1'b1;
      if (pme_en) pme_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake_d;
  end

  always_ff @(posedge clk or negedge aux_rst_n) begin
    if (!aux_rst_n) pme_q <= 1'b0;
    else            pme_q <= pme_d;
  end

  always_comb begin
    sts_rdata         = '0;
    sts_rdata[S_WAKE] = wake_q;
    sts_rdata[S_PME]  = pme_q;
  end

  assign wake_irq = wake_q && wake_ie;
  assign pme_req  = pme_q;

  // R6: wake status is only ever set out of the shut-off state
  a_r6_wake_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_q) |-> $past(link_off));
  // R7: PME status is only set when its enable was on
  a_r7_pme_gated: assert property (@(posedge clk) disable iff (!rst_n || !aux_rst_n)
    $rose(pme_q) |-> $past(pme_en));
endmodule

// File: rtl/aclink_pm_ctrl.sv
module aclink_pm_ctrl
  import aclink_pkg::*;
#(
  parameter int CLK_KHZ   = 250000,
  parameter int PULSE_NS  = 1200,
  parameter int STOP_IDLE = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        aux_rst_n,
  input  logic        ctrl_wr,
  input  logic [15:0] ctrl_wdata,
  output logic [15:0] ctrl_rdata,
  input  logic        sts_wr,
  input  logic [7:0]  sts_wdata,
  output logic [7:0]  sts_rdata,
  input  logic        bclk_in,
  output logic        bclk_stopped,
  input  logic        sync_core,
  input  logic        sdata_out_core,
  input  logic        sdata_in_pin,
  output logic        sdata_in_core,
  output logic        codec_rst_n,
  output logic        sync_out,
  output logic        sdata_out_pin,
  output logic        line_in_en,
  input  logic        gpi_sts,
  output logic        gpi_irq,
  output logic        wake_irq,
  output logic        pme_req
);
  localparam longint PROD      = longint'(PULSE_NS) * longint'(CLK_KHZ);
  localparam int     PULSE_CYC = int'((PROD + 64'd999999) / 64'd1000000);

  logic        rst_n_s, aux_n_s;
  logic        cold_start, warm_start, cold_act, warm_act, link_off;
  logic        gpi_prev_q, gpi_irq_d;
  ctl_fields_t fld;

  aclink_rst_sync u_rs_main (.clk(clk), .arst_n(rst_n),     .srst_n(rst_n_s));
  aclink_rst_sync u_rs_aux  (.clk(clk), .arst_n(aux_rst_n), .srst_n(aux_n_s));

  aclink_bclk_mon #(.STOP_IDLE(STOP_IDLE)) u_mon (
    .clk(clk), .rst_n(rst_n_s), .bclk_in(bclk_in), .stopped(bclk_stopped));

  aclink_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n_s), .aux_rst_n(aux_n_s),
    .wr_en(ctrl_wr), .wdata(ctrl_wdata), .bclk_stopped(bclk_stopped),
    .cold_busy(cold_act), .warm_busy(warm_act),
    .cold_start(cold_start), .warm_start(warm_start),
    .fields(fld), .rdata(ctrl_rdata));

  aclink_pulse_gen #(.CYC(PULSE_CYC)) u_cold (
    .clk(clk), .rst_n(rst_n_s), .start(cold_start), .active(cold_act));
  aclink_pulse_gen #(.CYC(PULSE_CYC)) u_warm (
    .clk(clk), .rst_n(rst_n_s), .start(warm_start), .active(warm_act));

  assign link_off = fld.shut_en && bclk_stopped;

  aclink_wake_det u_wake (
    .clk(clk), .rst_n(rst_n_s), .aux_rst_n(aux_n_s),
    .sdin_pin(sdata_in_pin), .link_off(link_off),
    .wake_ie(fld.wake_ie), .pme_en(fld.pme_en),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .sts_rdata(sts_rdata),
    .wake_irq(wake_irq), .pme_req(pme_req));

  // link pin drive
  assign codec_rst_n   = !(cold_act || link_off);
  assign sync_out      = warm_act || (sync_core && !link_off);
  assign sdata_out_pin = sdata_out_core && !link_off;
  assign line_in_en    = !link_off;
  assign sdata_in_core = fld.loop_en ? sdata_out_core : sdata_in_pin;

  // GPI change interrupt
  assign gpi_irq_d = fld.gpi_ie && (gpi_sts != gpi_prev_q);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      gpi_prev_q <= 1'b0;
      gpi_irq    <= 1'b0;
    end else begin
      gpi_prev_q <= gpi_sts;
      gpi_irq    <= gpi_irq_d;
    end
  end

  // R5: shut-off with stopped clock holds every link output low
  a_r5_shut_low: assert property (@(posedge clk) disable iff (!rst_n_s)
    (link_off && !warm_act) |-> (!sync_out && !codec_rst_n && !sdata_out_pin && !line_in_en));
  // R9: a GPI interrupt needs the enable in the previous cycle
  a_r9_gpi_gated: assert property (@(posedge clk) disable iff (!rst_n_s)
    gpi_irq |-> $past(fld.gpi_ie));
  // R2: warm pulse only begins while the bit clock is stopped
  a_r2_warm_needs_stop: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(warm_act) |-> $past(bclk_stopped));
endmodule

// File: tb/tb_aclink_pm_ctrl.sv
module tb_aclink_pm_ctrl;
  localparam int STOP = 16;
  localparam int PCYC = 300; // 1.2 us at 250 MHz

  logic clk = 0, rst_n = 0, aux_rst_n = 0;
  logic ctrl_wr = 0, sts_wr = 0;
  logic [15:0] ctrl_wdata = 0, ctrl_rdata;
  logic [7:0]  sts_wdata = 0, sts_rdata;
  logic bclk = 0, bclk_run = 1, bclk_stopped;
  logic sync_core = 0, sdata_out_core = 0, sdata_in_pin = 0, sdata_in_core;
  logic codec_rst_n, sync_out, sdata_out_pin, line_in_en;
  logic gpi_sts = 0, gpi_irq, wake_irq, pme_req;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always #12 if (bclk_run) bclk = ~bclk;

  aclink_pm_ctrl #(.CLK_KHZ(250000), .PULSE_NS(1200), .STOP_IDLE(STOP)) dut (
    .clk(clk), .rst_n(rst_n), .aux_rst_n(aux_rst_n),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .sts_rdata(sts_rdata),
    .bclk_in(bclk), .bclk_stopped(bclk_stopped),
    .sync_core(sync_core), .sdata_out_core(sdata_out_core),
    .sdata_in_pin(sdata_in_pin), .sdata_in_core(sdata_in_core),
    .codec_rst_n(codec_rst_n), .sync_out(sync_out),
    .sdata_out_pin(sdata_out_pin), .line_in_en(line_in_en),
    .gpi_sts(gpi_sts), .gpi_irq(gpi_irq), .wake_irq(wake_irq), .pme_req(pme_req));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [15:0] d);
    ctrl_wr = 1; ctrl_wdata = d;
    @(negedge clk);
    ctrl_wr = 0; ctrl_wdata = 0;
  endtask

  task automatic wr_sts(input logic [7:0] d);
    sts_wr = 1; sts_wdata = d;
    @(negedge clk);
    sts_wr = 0; sts_wdata = 0;
  endtask

  task automatic bclk_set(input logic run);
    bclk_run = run;
    cyc(STOP + 12);
  endtask

  initial begin
    int n;
    @(negedge clk);
    cyc(3);
    rst_n = 1; aux_rst_n = 1;
    cyc(8);
    // reset state
    chk("R11 reset ctrl", ctrl_rdata, 0);
    chk("R7 reset sts", sts_rdata, 0);
    chk("R1 reset codec_rst_n", codec_rst_n, 1);
    chk("R4 running after reset", bclk_stopped, 0);
    chk("R5 line_in after reset", line_in_en, 1);

    // R11: reserved bits
    wr_ctrl(16'hFF40);
    chk("R11 reserved read 0", ctrl_rdata, 0);
    wr_ctrl(16'h00B1);
    chk("R11 writable bits", ctrl_rdata, 16'h00B1);
    wr_ctrl(16'h0000);

    // R1: cold reset pulse
    wr_ctrl(16'h0002);
    chk("R1 bit1 busy", ctrl_rdata[1], 1);
    n = 0;
    while (!codec_rst_n && n < 2000) begin n++; @(negedge clk); end
    chk("R1 cold width", n, PCYC);
    chk("R1 bit1 cleared", ctrl_rdata[1], 0);

    // R3: warm ignored while running
    sync_core = 0;
    wr_ctrl(16'h0004);
    chk("R3 bit2 stays 0", ctrl_rdata[2], 0);
    n = 0;
    for (int i = 0; i < PCYC + 10; i++) begin
      if (sync_out) n++;
      @(negedge clk);
    end
    chk("R3 no sync pulse", n, 0);

    // R4: threshold
    bclk_run = 0;
    cyc(STOP - 4);
    chk("R4 not yet stopped", bclk_stopped, 0);
    cyc(10);
    chk("R4 stopped", bclk_stopped, 1);
    bclk_run = 1;
    cyc(10);
    chk("R4 restarts", bclk_stopped, 0);

    // R2: warm pulse while stopped
    bclk_set(0);
    wr_ctrl(16'h0004);
    chk("R2 bit2 busy", ctrl_rdata[2], 1);
    n = 0;
    while (sync_out && n < 2000) begin n++; @(negedge clk); end
    chk("R2 warm width", n, PCYC);
    chk("R2 bit2 self clear", ctrl_rdata[2], 0);

    // R5: sweep shut-off, clock state and core levels
    for (int sh = 0; sh < 2; sh++)
      for (int run = 0; run < 2; run++)
        for (int dv = 0; dv < 2; dv++) begin
          logic off;
          wr_ctrl(sh ? 16'h0008 : 16'h0000);
          sync_core = dv[0]; sdata_out_core = dv[0];
          bclk_set(run[0]);
          off = sh[0] && !run[0];
          chk("R5 codec_rst_n", codec_rst_n, !off);
          chk("R5 sync_out", sync_out, dv[0] && !off);
          chk("R5 sdata_out_pin", sdata_out_pin, dv[0] && !off);
          chk("R5 line_in_en", line_in_en, !off);
        end
    sync_core = 0; sdata_out_core = 0;

    // R6/R7: wake sweep over enables and shut-off
    bclk_set(0);
    for (int sh = 0; sh < 2; sh++)
      for (int en = 0; en < 4; en++) begin
        logic [15:0] w;
        w = 16'h0;
        w[3] = sh[0]; w[4] = en[0]; w[5] = en[1];
        wr_ctrl(w);
        sdata_in_pin = 0; cyc(5);
        sdata_in_pin = 1; cyc(6);
        chk("R6 wake status", sts_rdata[4], sh[0]);
        chk("R7 wake_irq", wake_irq, sh[0] && en[0]);
        chk("R7 pme_req", pme_req, sh[0] && en[1]);
        chk("R7 pme status", sts_rdata[5], sh[0] && en[1]);
        wr_sts(8'h30);
        chk("R7 w1c clears", {wake_irq, pme_req, sts_rdata}, 0);
        sdata_in_pin = 0; cyc(4);
      end
    wr_ctrl(16'h0000);
    bclk_set(1);

    // R8: loopback sweep
    for (int v = 0; v < 8; v++) begin
      wr_ctrl(v[2] ? 16'h0080 : 16'h0000);
      sdata_out_core = v[0]; sdata_in_pin = v[1];
      #1;
      chk("R8 sdata_in_core", sdata_in_core, v[2] ? v[0] : v[1]);
    end
    sdata_out_core = 0; sdata_in_pin = 0;

    // R9: GPI change interrupt
    for (int e = 0; e < 2; e++) begin
      wr_ctrl(e ? 16'h0001 : 16'h0000);
      cyc(2);
      for (int t = 0; t < 2; t++) begin
        gpi_sts = ~gpi_sts;
        @(negedge clk);
        chk("R9 irq on change", gpi_irq, e[0]);
        @(negedge clk);
        chk("R9 irq one cycle", gpi_irq, 0);
      end
      cyc(3);
      chk("R9 no irq steady", gpi_irq, 0);
    end

    // R10: sticky bits across main reset
    wr_ctrl(16'h00B9);
    bclk_set(0);
    sdata_in_pin = 1; cyc(6); sdata_in_pin = 0;
    chk("R10 pme before reset", pme_req, 1);
    rst_n = 0; cyc(3); rst_n = 1; cyc(6);
    chk("R10 sticky kept", ctrl_rdata, 16'h0028);
    chk("R10 pme kept", sts_rdata, 8'h20);
    aux_rst_n = 0; cyc(3); aux_rst_n = 1; cyc(6);
    chk("R10 aux clears", ctrl_rdata, 0);
    chk("R10 aux clears pme", pme_req, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule